// File: doc/BRIEF.md
# Aligned Divide-by-2 and Divide-by-4/6 Clock Generator

This block derives two slower clocks from one fast input clock. One output runs at half the input rate; the other runs at a quarter or a sixth of it, picked by a select input. Both are decoded from a single phase counter and leave flops on the same rising edge, so every rising edge they share falls on the same input cycle. A marker output goes high for one input cycle just before each shared rising edge, so downstream logic can find the common phase without watching both clocks.

A hold input freezes both divided clocks. It is captured on the falling edge of the input clock, so a freeze or release lands on a rising edge that follows a stable sample and never cuts a divided-clock level short. A synchronous, active-high reset puts all outputs low and the counter at a fixed point. Several copies reset on the same edge then stay in lockstep.

Top module: `clk_div_gen`

## Requirements
- R1: When `rst_i` is high at a rising edge of `clk_i`, all three outputs are low after that edge, whatever `hold_i` and `sel6_i` are.
- R2: Only the value of `hold_i` at the falling edge of `clk_i` counts. It decides whether the next rising edge advances. A pulse on `hold_i` that starts after one falling edge and ends before the next has no effect.
- R3: `div2_o` toggles on every advancing rising edge. The first advancing edge after reset drives it high.
- R4: With `sel6_i` low, `div46_o` is high for 2 advancing edges and then low for 2, a period of 4 input cycles.
- R5: With `sel6_i` high, `div46_o` is high for 3 advancing edges and then low for 3, a period of 6 input cycles.
- R6: The first advancing edge after reset takes `div2_o` and `div46_o` high on the same edge. From then on, every rising edge of `div46_o` is also a rising edge of `div2_o`.
- R7: `phase_o` is high for exactly one cycle. It rises on the advancing edge that leaves both divided outputs low one edge before their shared rise. It is low at all other times, including before the first rise after reset.
- R8: A held rising edge leaves `div2_o` and `div46_o` unchanged and drives `phase_o` low. The next advancing edge resumes the sequence from the point where it stopped.
- R9: The internal phase counter never goes past the last value of the selected divide ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hold_i | input | 1 | High freezes the divided clocks; sampled on the falling edge |
| sel6_i | input | 1 | Ratio select: 0 gives divide-by-4, 1 gives divide-by-6 |
| div2_o | output | 1 | Input clock divided by 2 |
| div46_o | output | 1 | Input clock divided by 4 or 6 |
| phase_o | output | 1 | One-cycle marker before each shared rising edge |

## Verification
The assertions assume that `sel6_i` changes only while reset is applied or while the sampled hold is active. A change in mid-count could leave the counter beyond a shorter wrap point. The checks on the hold path also assume that `rst_i` is driven to a known level from the first edge. The stimulus sets the select only inside a reset window that spans at least three edges. It changes `hold_i` and `rst_i` one nanosecond after a rising edge, which is well clear of both clock edges. The one exception is the deliberate short hold pulse, which is placed between a falling edge and the next falling edge.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Smallest counter width that can hold the values 0 .. ratio-1
  function automatic int ctr_width(input int ratio);
    int w;
    w = 1;
    while ((1 << w) < ratio) w++;
    return w;
  endfunction

  // Bundle of the three registered outputs
  typedef struct packed {
    logic half;
    logic slow;
    logic mark;
  } div_outs_t;

endpackage

// File: rtl/clkdiv_hold_sync.sv
`timescale 1ns/1ps
module clkdiv_hold_sync (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hold_i,
  output logic hold_q_o
);

  // Captured on the falling edge so that a freeze or release only acts on
  // the following rising edge, while every divided level is stable.
  always_ff @(negedge clk_i) begin
    if (rst_i) hold_q_o <= 1'b0;
    else       hold_q_o <= hold_i;
  end

endmodule

// File: rtl/clkdiv_phase_ctr.sv
`timescale 1ns/1ps
module clkdiv_phase_ctr #(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6,
  parameter int CNT_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             adv_i,
  input  logic             sel_hi_i,
  output logic [CNT_W-1:0] nxt_o,
  output logic [CNT_W-1:0] last_o,
  output logic [CNT_W-1:0] half_o
);

  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);
  localparam logic [CNT_W-1:0] HALF_LO = CNT_W'(DIV_LO / 2);
  localparam logic [CNT_W-1:0] HALF_HI = CNT_W'(DIV_HI / 2);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    last_o = sel_hi_i ? LAST_HI : LAST_LO;
    half_o = sel_hi_i ? HALF_HI : HALF_LO;
    nxt_o  = (cnt_q >= last_o) ? '0 : cnt_q + CNT_W'(1);
  end

  // Reset parks the counter at the wrap value, so the first advance lands on 0
  always_ff @(posedge clk_i) begin
    if (rst_i)      cnt_q <= last_o;
    else if (adv_i) cnt_q <= nxt_o;
  end

  // R9: never beyond the wrap value of the selected ratio
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= last_o);

  // R8: a held edge does not move the counter
  a_r8_ctr_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
    !adv_i |=> $stable(cnt_q));

endmodule

// File: rtl/clkdiv_out_regs.sv
`timescale 1ns/1ps
module clkdiv_out_regs
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic [CNT_W-1:0] last_i,
  input  logic [CNT_W-1:0] half_i,
  output div_outs_t        outs_o
);

  div_outs_t outs_q;

  // Outputs are decoded from the counter's next value and registered, so
  // both clocks leave flops on the same edge.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      outs_q <= '0;
    end else if (adv_i) begin
      outs_q.half <= ~nxt_i[0];
      outs_q.slow <= (nxt_i < half_i);
      outs_q.mark <= (nxt_i == last_i);
    end else begin
      outs_q.mark <= 1'b0;
    end
  end

  assign outs_o = outs_q;

  // R3: divide-by-2 flips on every advancing edge
  a_r3_half_toggles: assert property (@(posedge clk_i) disable iff (rst_i)
    adv_i |=> (outs_q.half != $past(outs_q.half)));

  // R6: the slow clock never rises unless the fast one rises too
  a_r6_aligned_rise: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(outs_q.slow) |-> $rose(outs_q.half));

endmodule

// File: rtl/clk_div_gen.sv
`timescale 1ns/1ps
module clk_div_gen
  import clkdiv_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hold_i,
  input  logic sel6_i,
  output logic div2_o,
  output logic div46_o,
  output logic phase_o
);

  localparam int CNT_W = ctr_width(DIV_HI);

  logic             hold_q;
  logic             adv;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] half;
  div_outs_t        outs;

  clkdiv_hold_sync u_hold (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .hold_i   (hold_i),
    .hold_q_o (hold_q)
  );

  assign adv = ~hold_q;

  clkdiv_phase_ctr #(
    .DIV_LO (DIV_LO),
    .DIV_HI (DIV_HI),
    .CNT_W  (CNT_W)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .adv_i    (adv),
    .sel_hi_i (sel6_i),
    .nxt_o    (nxt),
    .last_o   (last),
    .half_o   (half)
  );

  clkdiv_out_regs #(
    .CNT_W (CNT_W)
  ) u_out (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .adv_i  (adv),
    .nxt_i  (nxt),
    .last_i (last),
    .half_i (half),
    .outs_o (outs)
  );

  assign div2_o  = outs.half;
  assign div46_o = outs.slow;
  assign phase_o = outs.mark;

  // R1: reset clears every output on the next edge
  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (!div2_o && !div46_o && !phase_o));

  // R8: a held edge freezes both clocks and drops the marker
  a_r8_hold_freezes: assert property (@(posedge clk_i) disable iff (rst_i)
    hold_q |=> ($stable(div2_o) && $stable(div46_o) && !phase_o));

  // R7: the marker is followed by a shared rise when the edge advances
  a_r7_mark_before_rise: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_o && !hold_q) |=> (div2_o && div46_o));

  // R7: the marker lasts one cycle
  a_r7_mark_single: assert property (@(posedge clk_i) disable iff (rst_i)
    phase_o |=> !phase_o);

  // Input assumption: the ratio select moves only in reset or hold
  a_r9_sel_idle_only: assert property (@(posedge clk_i) disable iff (rst_i)
    !hold_q |-> $stable(sel6_i));

endmodule

// File: tb/tb_clk_div_gen.sv
`timescale 1ns/1ps
module tb_clk_div_gen;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold = 1'b0;
  logic sel = 1'b0;
  logic div2, div46, phase;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  clk_div_gen dut (
    .clk_i   (clk),
    .rst_i   (rst),
    .hold_i  (hold),
    .sel6_i  (sel),
    .div2_o  (div2),
    .div46_o (div46),
    .phase_o (phase)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {div2,div46,phase} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected outputs after the given number of advancing edges since reset
  function automatic logic [2:0] model(input bit s6, input int step);
    int n, p;
    if (step == 0) return 3'b000;
    n = s6 ? 6 : 4;
    p = (step - 1) % n;
    return {(p % 2) == 0, p < (n / 2), p == (n - 1)};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input bit s6);
    rst = 1'b1; hold = 1'b0; sel = s6;
    repeat (3) tick();
    chk("R1 reset", {div2, div46, phase}, 3'b000);
    rst = 1'b0;
  endtask

  task automatic run_steps(input bit s6, input int first, input int count);
    for (int i = 0; i < count; i++) begin
      logic [2:0] e;
      tick();
      e = model(s6, first + i);
      chk("R3 div2", {div2, 2'b00}, {e[2], 2'b00});
      chk(s6 ? "R5 div6" : "R4 div4", {1'b0, div46, 1'b0}, {1'b0, e[1], 1'b0});
      chk("R7 phase", {2'b00, phase}, {2'b00, e[0]});
    end
  endtask

  task automatic test_reset();
    rst = 1'b1; hold = 1'b1; sel = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R1 reset with hold", {div2, div46, phase}, 3'b000);
    end
    hold = 1'b0;
  endtask

  task automatic test_div4();
    do_reset(1'b0);
    tick();
    chk("R6 first common rise", {div2, div46, phase}, 3'b110);
    run_steps(1'b0, 2, 11);
  endtask

  task automatic test_div6();
    do_reset(1'b1);
    tick();
    chk("R6 first common rise div6", {div2, div46, phase}, 3'b110);
    run_steps(1'b1, 2, 17);
  endtask

  task automatic test_hold();
    do_reset(1'b0);
    run_steps(1'b0, 1, 4);
    hold = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R8 hold at marker", {div2, div46, phase}, 3'b000);
    end
    hold = 1'b0;
    tick();
    chk("R8 resume", {div2, div46, phase}, model(1'b0, 5));
    run_steps(1'b0, 6, 4);
    do_reset(1'b1);
    run_steps(1'b1, 1, 2);
    hold = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R8 hold div6", {div2, div46, phase}, model(1'b1, 2) & 3'b110);
    end
    hold = 1'b0;
    run_steps(1'b1, 3, 6);
  endtask

  task automatic test_short_pulse();
    do_reset(1'b1);
    run_steps(1'b1, 1, 2);
    #2;
    hold = 1'b1;
    @(posedge clk);
    #1;
    hold = 1'b0;
    chk("R2 short hold ignored", {div2, div46, phase}, model(1'b1, 3));
    run_steps(1'b1, 4, 4);
  endtask

  task automatic test_midrun_reset();
    do_reset(1'b1);
    run_steps(1'b1, 1, 4);
    rst = 1'b1;
    tick();
    chk("R1 mid-run reset", {div2, div46, phase}, 3'b000);
    do_reset(1'b0);
    tick();
    chk("R6 restart after reset", {div2, div46, phase}, 3'b110);
    run_steps(1'b0, 2, 7);
  endtask

  initial begin
    test_reset();
    test_div4();
    test_div6();
    test_hold();
    test_short_pulse();
    test_midrun_reset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule